// File: doc/BRIEF.md
# Refresh-Pausing Rank Scheduler

This block manages refresh for one DRAM rank from the controller side. It decides, cycle by cycle, whether the rank serves a read, a write or a refresh. The rank can only do one of these at a time. An interval timer creates one refresh obligation per refresh interval. The interval is the retention time divided by 8192, and it is held in the `INTERVAL_BASE` parameter in clock cycles. The block counts these obligations as owed refreshes and works them off one bundle at a time. While a bundle is being refreshed, the refresh enable line is held high.

A normal refresh gives way to reads. It is not started while a read is waiting. If a read arrives during a bundle, the enable line drops after the row in flight completes. The remaining time of the bundle is kept, and the refresh resumes once the reads drain. Writes do not get in ahead of a resume. Once the owed count reaches the postponement limit, the next refresh is forced: it starts, or a paused one resumes, even with reads waiting, and it runs to the end without pausing.

Two mode inputs scale the timing. A granularity select divides both the interval and the per-bundle refresh time by 1, 2 or 4. A high-temperature flag halves the interval again.

Top module: `refresh_pause_sched`

## Requirements
- R1: At most one of `grant_rd`, `grant_wr` and `ref_en` is high in any cycle. `grant_rd` is high when a read is pending, no refresh runs and none is being forced. `grant_wr` is high only when a write is pending, no read is pending, no refresh runs and no refresh is being started or resumed in that cycle.
- R2: The refresh interval in cycles is `INTERVAL_BASE >> (g + hot_mode)`, where g is 0, 1 or 2 for `gran_mode` values 0, 1 and 2 (value 3 acts as 2). With the interval I, `owed_cnt` first increments at the I-th clock edge after reset release, and again every I edges after that.
- R3: `owed_cnt` never exceeds `OWED_LIMIT` and decrements at the edge that ends a bundle. If an interval tick and a bundle end fall in the same cycle, the count is unchanged.
- R4: In the cycle where `owed_cnt` equals `OWED_LIMIT` with no refresh running, `grant_rd` is low. At the next edge a forced refresh starts (`ref_forced` high). `ref_en` then stays high for the whole bundle even while reads are pending.
- R5: If a read is pending while a non-forced refresh runs, `ref_en` goes low at the next edge and `grant_rd` rises. That last cycle still counts as refresh work.
- R6: `rem_cnt` decrements by one at each edge where `ref_en` is high and holds its value while `ref_en` is low. The bundle ends when it reaches zero, so `ref_en` is high for exactly the bundle time in total, across any pauses.
- R7: The bundle time loaded at the start of a refresh is `RFC_BASE >> g`, with g as in R2.
- R8: A paused refresh resumes at the edge after no read is pending. In the cycle of that decision `grant_wr` stays low even with a write pending. A resume does not pulse `ref_start`.
- R9: If `owed_cnt` reaches `OWED_LIMIT` while a refresh is paused, that refresh resumes as forced at the next edge, with reads still pending and the remaining time kept.
- R10: A new normal refresh starts only when `owed_cnt` is nonzero and no read is pending. `ref_start` is high for exactly the first cycle of a bundle, together with `ref_en`.
- R11: During and right after reset, `ref_en`, `ref_start`, `ref_forced`, `owed_cnt` and `rem_cnt` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_pend | input | 1 | At least one read is waiting for the rank |
| wr_pend | input | 1 | At least one write is waiting for the rank |
| gran_mode | input | 2 | Refresh granularity: 0 = 1x, 1 = 2x, 2 or 3 = 4x |
| hot_mode | input | 1 | High-temperature operation, halves the interval |
| ref_en | output | 1 | Refresh enable to the rank; low pauses or idles refresh |
| ref_start | output | 1 | One-cycle pulse on the first cycle of a new bundle |
| ref_forced | output | 1 | The running or paused bundle is a forced, non-pausable one |
| grant_rd | output | 1 | The rank serves a read this cycle |
| grant_wr | output | 1 | The rank serves a write this cycle |
| owed_cnt | output | $clog2(OWED_LIMIT+1) | Refreshes owed, including the one in progress |
| rem_cnt | output | $clog2(RFC_BASE+1) | Cycles of refresh work left in the current bundle |

## Verification
The bench targets several corner cases:
- An interval tick that lands on the same cycle as a bundle end. A design that counts both events would show the owed count moving by one where it should hold.
- A refresh paused by a read and then resumed. Here the bench checks that the remaining time is kept through the pause, that the pause and resume together add up to exactly one bundle, and that a waiting write does not slip in at the resume.
- The escalation paths. A read stream held long enough must raise a forced refresh that ignores reads. A paused bundle must turn forced, and a design that kept it paused would never let `ref_en` rise again.
- The mode settings. Each one is run to measure both the gap between ticks and the loaded bundle time, which catches a wrong shift.

// File: rtl/rp_pkg.sv
// Shared types and helpers for the refresh-pausing scheduler.
package rp_pkg;

    // Refresh engine state: nothing running, bundle in progress, bundle paused
    typedef enum logic [1:0] {
        RP_IDLE = 2'd0,
        RP_RUN  = 2'd1,
        RP_HOLD = 2'd2
    } rp_state_e;

    // Granularity select to shift amount: 0 -> /1, 1 -> /2, 2 or 3 -> /4
    function automatic logic [1:0] gran_shift(input logic [1:0] g);
        logic [1:0] s;
        case (g)
            2'd0:    s = 2'd0;
            2'd1:    s = 2'd1;
            default: s = 2'd2;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/rp_interval_timer.sv
// Interval timer: raises tick for one cycle once per refresh interval.
// Assumes: INTERVAL_BASE is a multiple of 8, so that every mode gives an
// interval of at least 1; a mode change only reshapes the current interval.
module rp_interval_timer #(
    parameter int INTERVAL_BASE = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] gran_mode,
    input  logic       hot_mode,
    output logic       tick
);
    import rp_pkg::*;

    localparam int CW = $clog2(INTERVAL_BASE + 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] intv;
    logic [2:0]    shamt;

    // Derive the interval length from the mode inputs
    always_comb begin
        shamt = {1'b0, gran_shift(gran_mode)} + {2'b00, hot_mode};
        intv  = CW'(INTERVAL_BASE) >> shamt;
    end

    // Tick in the last cycle of each interval
    always_comb tick = (cnt_q >= (intv - CW'(1)));

    // Advance the phase counter, wrapping at the interval end
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (tick) cnt_q <= '0;
        else           cnt_q <= cnt_q + CW'(1);
    end

endmodule

// File: rtl/rp_owed_tracker.sv
// Owed-refresh counter: counts interval ticks up and finished bundles down.
// Assumes: done only arrives while the count is nonzero (the engine only
// runs a bundle when a refresh is owed).
module rp_owed_tracker #(
    parameter int OWED_LIMIT = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tick,
    input  logic                              done,
    output logic [$clog2(OWED_LIMIT+1)-1:0]   owed_cnt,
    output logic                              owed_any,
    output logic                              owed_full
);
    localparam int OW = $clog2(OWED_LIMIT + 1);

    logic [OW-1:0] owed_q;

    // Count up on ticks (saturating), down on bundle ends, hold on a tie
    always_ff @(posedge clk) begin
        if (!rst_n)
            owed_q <= '0;
        else if (tick && !done && (owed_q < OW'(OWED_LIMIT)))
            owed_q <= owed_q + OW'(1);
        else if (done && !tick)
            owed_q <= owed_q - OW'(1);
    end

    // Status decodes for the engine
    always_comb begin
        owed_cnt  = owed_q;
        owed_any  = (owed_q != '0);
        owed_full = (owed_q == OW'(OWED_LIMIT));
    end

endmodule

// File: rtl/rp_refresh_engine.sv
// Refresh engine: starts, pauses, resumes and finishes refresh bundles.
// Keeps the remaining work of a paused bundle and escalates to a forced,
// non-pausable bundle when the owed count is full.
// Assumes: RFC_BASE >= 4 so a 4x bundle lasts at least one cycle.
module rp_refresh_engine #(
    parameter int RFC_BASE = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_pend,
    input  logic                             owed_any,
    input  logic                             owed_full,
    input  logic [1:0]                       gran_mode,
    output logic                             ref_en,
    output logic                             ref_start,
    output logic                             ref_forced,
    output logic [$clog2(RFC_BASE+1)-1:0]    rem_cnt,
    output logic                             done,
    output logic                             claim_any,
    output logic                             claim_forced
);
    import rp_pkg::*;

    localparam int RW = $clog2(RFC_BASE + 1);

    rp_state_e     state_q, state_d;
    logic [RW-1:0] rem_q, rem_d;
    logic [RW-1:0] rfc_load;
    logic          forced_q, forced_d;
    logic          start_q, start_d;

    // Bundle length for the selected granularity
    always_comb rfc_load = RW'(RFC_BASE) >> gran_shift(gran_mode);

    // Next-state logic for start, pause, resume, escalation and completion
    always_comb begin
        state_d      = state_q;
        rem_d        = rem_q;
        forced_d     = forced_q;
        start_d      = 1'b0;
        done         = 1'b0;
        claim_any    = 1'b0;
        claim_forced = 1'b0;
        case (state_q)
            RP_IDLE: begin
                if (owed_full) begin
                    claim_any    = 1'b1;
                    claim_forced = 1'b1;
                    state_d      = RP_RUN;
                    rem_d        = rfc_load;
                    forced_d     = 1'b1;
                    start_d      = 1'b1;
                end else if (owed_any && !rd_pend) begin
                    claim_any = 1'b1;
                    state_d   = RP_RUN;
                    rem_d     = rfc_load;
                    forced_d  = 1'b0;
                    start_d   = 1'b1;
                end
            end
            RP_RUN: begin
                rem_d = rem_q - RW'(1);
                if (rem_q == RW'(1)) begin
                    done     = 1'b1;
                    state_d  = RP_IDLE;
                    forced_d = 1'b0;
                end else if (!forced_q && rd_pend) begin
                    state_d = RP_HOLD;
                end
            end
            RP_HOLD: begin
                if (owed_full) begin
                    claim_any    = 1'b1;
                    claim_forced = 1'b1;
                    forced_d     = 1'b1;
                    state_d      = RP_RUN;
                end else if (!rd_pend) begin
                    claim_any = 1'b1;
                    state_d   = RP_RUN;
                end
            end
            default: state_d = RP_IDLE;
        endcase
    end

    // Register the engine state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= RP_IDLE;
            rem_q    <= '0;
            forced_q <= 1'b0;
            start_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            rem_q    <= rem_d;
            forced_q <= forced_d;
            start_q  <= start_d;
        end
    end

    // Drive the outputs from registered state
    always_comb begin
        ref_en     = (state_q == RP_RUN);
        ref_start  = start_q;
        ref_forced = forced_q;
        rem_cnt    = rem_q;
    end

endmodule

// File: rtl/rp_grant_arbiter.sv
// Grant arbiter: gives the rank to a read or a write when refresh does not
// hold it. Reads beat writes; refresh work being claimed beats writes, and a
// forced claim beats reads as well.
module rp_grant_arbiter (
    input  logic rd_pend,
    input  logic wr_pend,
    input  logic ref_en,
    input  logic claim_any,
    input  logic claim_forced,
    output logic grant_rd,
    output logic grant_wr
);
    // Priority decode: forced refresh > read > refresh claim > write
    always_comb begin
        grant_rd = rd_pend && !ref_en && !claim_forced;
        grant_wr = wr_pend && !rd_pend && !ref_en && !claim_any;
    end

endmodule

// File: rtl/refresh_pause_sched.sv
// Refresh-pausing rank scheduler (top). Ties the interval timer, the owed
// counter, the refresh engine and the grant arbiter together.
// Assumes: mode inputs change only while no refresh is running; INTERVAL_BASE
// is the retention time over 8192 in clock cycles.
module refresh_pause_sched #(
    parameter int INTERVAL_BASE = 64,
    parameter int RFC_BASE      = 16,
    parameter int OWED_LIMIT    = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_pend,
    input  logic                             wr_pend,
    input  logic [1:0]                       gran_mode,
    input  logic                             hot_mode,
    output logic                             ref_en,
    output logic                             ref_start,
    output logic                             ref_forced,
    output logic                             grant_rd,
    output logic                             grant_wr,
    output logic [$clog2(OWED_LIMIT+1)-1:0]  owed_cnt,
    output logic [$clog2(RFC_BASE+1)-1:0]    rem_cnt
);
    logic tick;
    logic done;
    logic owed_any;
    logic owed_full;
    logic claim_any;
    logic claim_forced;

    rp_interval_timer #(
        .INTERVAL_BASE(INTERVAL_BASE)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .gran_mode (gran_mode),
        .hot_mode  (hot_mode),
        .tick      (tick)
    );

    rp_owed_tracker #(
        .OWED_LIMIT(OWED_LIMIT)
    ) u_owed (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .done      (done),
        .owed_cnt  (owed_cnt),
        .owed_any  (owed_any),
        .owed_full (owed_full)
    );

    rp_refresh_engine #(
        .RFC_BASE(RFC_BASE)
    ) u_engine (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_pend      (rd_pend),
        .owed_any     (owed_any),
        .owed_full    (owed_full),
        .gran_mode    (gran_mode),
        .ref_en       (ref_en),
        .ref_start    (ref_start),
        .ref_forced   (ref_forced),
        .rem_cnt      (rem_cnt),
        .done         (done),
        .claim_any    (claim_any),
        .claim_forced (claim_forced)
    );

    rp_grant_arbiter u_arb (
        .rd_pend      (rd_pend),
        .wr_pend      (wr_pend),
        .ref_en       (ref_en),
        .claim_any    (claim_any),
        .claim_forced (claim_forced),
        .grant_rd     (grant_rd),
        .grant_wr     (grant_wr)
    );

endmodule

// File: rtl/refresh_pause_sched_chk.sv
// Checker for refresh_pause_sched: temporal properties on its ports.
module refresh_pause_sched_chk #(
    parameter int RFC_BASE   = 16,
    parameter int OWED_LIMIT = 8
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             rd_pend,
    input logic                             wr_pend,
    input logic                             ref_en,
    input logic                             ref_start,
    input logic                             ref_forced,
    input logic                             grant_rd,
    input logic                             grant_wr,
    input logic [$clog2(OWED_LIMIT+1)-1:0]  owed_cnt,
    input logic [$clog2(RFC_BASE+1)-1:0]    rem_cnt
);
    localparam int OW = $clog2(OWED_LIMIT + 1);
    localparam int RW = $clog2(RFC_BASE + 1);

    AST_ONE_SERVICE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0({grant_rd, grant_wr, ref_en})); // R1
    AST_WR_YIELDS: assert property (@(posedge clk) disable iff (!rst_n) grant_wr |-> !rd_pend); // R1
    AST_OWED_BOUND: assert property (@(posedge clk) disable iff (!rst_n) owed_cnt <= OW'(OWED_LIMIT)); // R3
    AST_FORCED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (ref_en && ref_forced && rem_cnt > RW'(1)) |=> ref_en); // R4
    AST_READ_PAUSES: assert property (@(posedge clk) disable iff (!rst_n) (ref_en && !ref_forced && rd_pend && rem_cnt > RW'(1)) |=> (!ref_en && grant_rd)); // R5
    AST_REM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!ref_en && rem_cnt != '0) |=> (rem_cnt == $past(rem_cnt))); // R6
    AST_REM_STEPS: assert property (@(posedge clk) disable iff (!rst_n) (ref_en && rem_cnt > RW'(1)) |=> (rem_cnt == $past(rem_cnt) - RW'(1))); // R6
    AST_BUNDLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (ref_en && rem_cnt == RW'(1)) |=> (!ref_en && rem_cnt == '0)); // R6
    AST_START_WITH_EN: assert property (@(posedge clk) disable iff (!rst_n) ref_start |-> ref_en); // R10
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ref_start |=> !ref_start); // R10
    AST_START_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (ref_start && !ref_forced) |-> $past(!rd_pend)); // R10

endmodule

bind refresh_pause_sched refresh_pause_sched_chk #(
    .RFC_BASE   (RFC_BASE),
    .OWED_LIMIT (OWED_LIMIT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_pend    (rd_pend),
    .wr_pend    (wr_pend),
    .ref_en     (ref_en),
    .ref_start  (ref_start),
    .ref_forced (ref_forced),
    .grant_rd   (grant_rd),
    .grant_wr   (grant_wr),
    .owed_cnt   (owed_cnt),
    .rem_cnt    (rem_cnt)
);

// File: tb/refresh_pause_sched_tb.sv
// Directed bench for refresh_pause_sched: one task per scenario.
module refresh_pause_sched_tb;

    localparam int IB  = 64;
    localparam int RB  = 16;
    localparam int LIM = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_pend = 1'b0;
    logic       wr_pend = 1'b0;
    logic [1:0] gran_mode = 2'd0;
    logic       hot_mode = 1'b0;
    logic       ref_en, ref_start, ref_forced, grant_rd, grant_wr;
    logic [$clog2(LIM+1)-1:0] owed_cnt;
    logic [$clog2(RB+1)-1:0]  rem_cnt;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int owed_max = 0;

    always #5 clk = ~clk;

    refresh_pause_sched #(
        .INTERVAL_BASE (IB),
        .RFC_BASE      (RB),
        .OWED_LIMIT    (LIM)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_pend    (rd_pend),
        .wr_pend    (wr_pend),
        .gran_mode  (gran_mode),
        .hot_mode   (hot_mode),
        .ref_en     (ref_en),
        .ref_start  (ref_start),
        .ref_forced (ref_forced),
        .grant_rd   (grant_rd),
        .grant_wr   (grant_wr),
        .owed_cnt   (owed_cnt),
        .rem_cnt    (rem_cnt)
    );

    // Edges since reset release, and the largest owed count seen
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end
    always @(negedge clk) if (rst_n && int'(owed_cnt) > owed_max) owed_max = int'(owed_cnt);

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] g, input logic h, input logic rd0, input logic wr0);
        @(negedge clk);
        rst_n = 1'b0; gran_mode = g; hot_mode = h; rd_pend = rd0; wr_pend = wr0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R11: outputs zero in and after reset
    task automatic t_reset();
        do_reset(2'd0, 1'b0, 1'b0, 1'b0);
        @(negedge clk);
        chk("R11 ref_en", int'(ref_en), 0);
        chk("R11 owed", int'(owed_cnt), 0);
        chk("R11 rem", int'(rem_cnt), 0);
        chk("R11 start/forced", int'(ref_start) + int'(ref_forced), 0);
    endtask

    // R2, R7: interval spacing and bundle length per mode
    task automatic t_mode(input logic [1:0] g, input logic h, input int iv, input int rfc);
        int first;
        do_reset(g, h, 1'b1, 1'b0);
        while (owed_cnt != 1) @(negedge clk);
        first = cyc;
        chk("R2 first tick edge", first, iv);
        while (owed_cnt != 2) @(negedge clk);
        chk("R2 tick spacing", cyc - first, iv);
        rd_pend = 1'b0;
        @(negedge clk);
        chk("R10 start pulse", int'(ref_start), 1);
        chk("R7 bundle load", int'(rem_cnt), rfc);
    endtask

    // R1, R5, R6, R8: pause by a read, hold, resume ahead of a write
    task automatic t_pause_resume();
        int high;
        do_reset(2'd0, 1'b0, 1'b0, 1'b1);
        @(negedge clk);
        chk("R1 write granted when idle", int'(grant_wr), 1);
        while (ref_start != 1'b1) @(negedge clk);
        chk("R10 normal start edge", cyc, IB + 1);
        chk("R1 write blocked by refresh", int'(grant_wr), 0);
        repeat (4) @(negedge clk);
        rd_pend = 1'b1;
        @(negedge clk);
        chk("R5 ref_en low after read", int'(ref_en), 0);
        chk("R5 read granted", int'(grant_rd), 1);
        chk("R6 rem after pause", int'(rem_cnt), RB - 5);
        chk("R1 write held while read", int'(grant_wr), 0);
        repeat (10) @(negedge clk);
        chk("R6 rem held while paused", int'(rem_cnt), RB - 5);
        rd_pend = 1'b0;
        #1;
        chk("R8 write not granted at resume", int'(grant_wr), 0);
        @(negedge clk);
        chk("R8 resumed", int'(ref_en), 1);
        chk("R8 no start pulse on resume", int'(ref_start), 0);
        high = 0;
        while (ref_en) begin high++; @(negedge clk); end
        chk("R6 remaining work after resume", high, RB - 5);
        chk("R3 owed after bundle", int'(owed_cnt), 0);
        chk("R1 write granted after refresh", int'(grant_wr), 1);
    endtask

    // R3, R4: continuous reads force a refresh at the limit
    task automatic t_forced();
        int high;
        do_reset(2'd0, 1'b0, 1'b1, 1'b0);
        while (owed_cnt != LIM) @(negedge clk);
        chk("R4 limit reached edge", cyc, IB * LIM);
        chk("R4 read held off at limit", int'(grant_rd), 0);
        @(negedge clk);
        chk("R4 forced start", int'(ref_en) + int'(ref_forced) + int'(ref_start), 3);
        high = 0;
        while (ref_en) begin high++; @(negedge clk); end
        chk("R4 forced bundle not paused", high, RB);
        chk("R3 owed after forced", int'(owed_cnt), LIM - 1);
        chk("R4 forced flag clears", int'(ref_forced), 0);
        chk("R4 read served after forced", int'(grant_rd), 1);
    endtask

    // R9: a paused bundle escalates to forced at the limit
    task automatic t_escalate();
        int high;
        do_reset(2'd0, 1'b0, 1'b0, 1'b0);
        while (ref_start != 1'b1) @(negedge clk);
        repeat (2) @(negedge clk);
        rd_pend = 1'b1;
        @(negedge clk);
        chk("R5 paused", int'(ref_en), 0);
        while (!ref_en) @(negedge clk);
        chk("R9 escalation edge", cyc, IB * LIM + 1);
        chk("R9 forced flag", int'(ref_forced), 1);
        chk("R9 remaining kept", int'(rem_cnt), RB - 3);
        chk("R9 no start pulse", int'(ref_start), 0);
        high = 0;
        while (ref_en) begin high++; @(negedge clk); end
        chk("R9 finishes with reads pending", high, RB - 3);
        chk("R3 owed after escalated bundle", int'(owed_cnt), LIM - 1);
    endtask

    // R3: tick and bundle end in the same cycle leave the count alone
    task automatic t_coincide();
        do_reset(2'd2, 1'b1, 1'b1, 1'b0);
        while (cyc != 11) @(negedge clk);
        chk("R3 owed before tie", int'(owed_cnt), 1);
        rd_pend = 1'b0;
        @(negedge clk);
        chk("R7 4x hot bundle", int'(rem_cnt), RB / 4);
        while (cyc != 15) @(negedge clk);
        chk("R6 last work cycle", int'(ref_en) * 100 + int'(rem_cnt), 101);
        @(negedge clk);
        chk("R3 tie keeps owed", int'(owed_cnt), 1);
        chk("R6 bundle ended", int'(ref_en), 0);
        rd_pend = 1'b1;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_mode(2'd0, 1'b0, IB,     RB);
        t_mode(2'd0, 1'b1, IB / 2, RB);
        t_mode(2'd1, 1'b0, IB / 2, RB / 2);
        t_mode(2'd2, 1'b0, IB / 4, RB / 4);
        t_mode(2'd2, 1'b1, IB / 8, RB / 4);
        t_pause_resume();
        t_forced();
        t_escalate();
        t_coincide();
        chk("R3 owed never above limit", owed_max, LIM);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule